// File: doc/BRIEF.md
# ATA PIO Strobe Timing Generator

This block runs one parallel-ATA programmed-I/O bus cycle at a time. A single-clock start pulse supplies the direction, the device number, the access class, the chip-select pattern, the register address and the write data. The block drives the chip selects, the address lines, the read and write strobes and the data-bus enable. It returns the captured read data, a one-clock done pulse and a busy flag. The live strobe, select and busy outputs double as the bus status.

Every cycle has four phases: address setup, strobe, hold and end-of-cycle. Each phase length comes from an 8-bit count taken from one of four timing words. The word is picked by the device (0 or 1) and by the class: a register access uses the command-block set and a data access uses the data-port set. Each device has its own enable for stretching the strobe on a synchronised ready input. Each device also has its own byte-swap enable, which applies to data-port words in both directions.

The controller is a state machine with six states: `ST_IDLE`, `ST_SETUP`, `ST_STROBE`, `ST_WAIT`, `ST_HOLD` and `ST_EOC`. Its transitions are:
- IDLE→SETUP when a start pulse arrives.
- SETUP→STROBE when the setup count expires.
- STROBE→HOLD when the strobe count expires and ready is either not needed or seen.
- STROBE→WAIT when the strobe count expires while ready is needed and low.
- WAIT→HOLD when ready is seen.
- HOLD→EOC when the hold count expires.
- EOC→IDLE when the end count expires. This transition raises done.

Top module: `ata_pio_timer`

## Requirements
- R1: After reset and whenever idle: `ata_cs_n`=2'b11, `ata_da`=0, `ata_rd_n`=`ata_wr_n`=1, `ata_doe`=0, `busy`=0, `done`=0.
- R2: A start pulse seen while idle begins a cycle on the next clock. The phases run setup, then strobe, then hold, then end-of-cycle, and each lasts its count plus one clocks. During setup and hold the selects are driven and both strobes are high. During strobe, `ata_rd_n` is low for a read (`start_wr`=0) or `ata_wr_n` is low for a write. During end-of-cycle `ata_cs_n`=2'b11 and `busy` stays high.
- R3: Each timing word holds the setup count in [7:0], the strobe count in [15:8], the hold count in [23:16] and the end-of-cycle count in [31:24]. The word used is picked by the device and the class (`start_data`=1 for a data-port access), chosen from four separate ports.
- R4: From setup through hold, `ata_cs_n` equals the inverse of `start_cs` and `ata_da` equals `start_da`. Outside that span `ata_da` is 0.
- R5: If `rdy_en[dev]`=1, the strobe stays active after its count while the ready input, passed through two flops, is low. If ready rises just after strobe clock r, the strobe lasts max(count+1, r+2) clocks.
- R6: If `rdy_en[dev]`=0, the ready input has no effect on the strobe width.
- R7: On a read, `rd_data` takes `ata_din` on the clock edge that ends the strobe. `rd_data` keeps that value through later write cycles.
- R8: On a write, `ata_doe`=1 and `ata_dout` carries the write data from the first setup clock through the last hold clock. `ata_doe` is 0 in end-of-cycle and idle, and is never high while `ata_rd_n` is low.
- R9: If `swap_en[dev]`=1 and the access is data-port, the two bytes are exchanged on both write and read data. Register accesses are never swapped.
- R10: A start pulse while `busy` is high is ignored. It has no effect on the current cycle and does not launch another one.
- R11: `done` is high for exactly one clock: the first clock after `busy` falls.
- R12: `dev_sel` shows the device of the most recently accepted cycle and holds it until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-clock launch request |
| start_dev | input | 1 | Device number of the request |
| start_data | input | 1 | 1 = data-port access, 0 = register access |
| start_wr | input | 1 | 1 = write, 0 = read |
| start_cs | input | CS_W | Chip selects to assert (1 = asserted) |
| start_da | input | ADDR_W | Register address |
| start_wdata | input | DATA_W | Write data |
| tim_reg_d0 | input | 32 | Register timing word, device 0 |
| tim_data_d0 | input | 32 | Data timing word, device 0 |
| tim_reg_d1 | input | 32 | Register timing word, device 1 |
| tim_data_d1 | input | 32 | Data timing word, device 1 |
| rdy_en | input | 2 | Per-device ready-stretch enable |
| swap_en | input | 2 | Per-device data byte-swap enable |
| ata_ready | input | 1 | Asynchronous device ready |
| ata_din | input | DATA_W | Data bus from the device |
| ata_cs_n | output | CS_W | Active-low chip selects |
| ata_da | output | ADDR_W | Register address lines |
| ata_rd_n | output | 1 | Active-low read strobe |
| ata_wr_n | output | 1 | Active-low write strobe |
| ata_dout | output | DATA_W | Data bus to the device |
| ata_doe | output | 1 | Data bus drive enable |
| rd_data | output | DATA_W | Captured read data |
| done | output | 1 | Cycle-complete pulse |
| busy | output | 1 | Cycle in progress |
| dev_sel | output | 1 | Device of the current or last cycle |

## Verification
The bench sweeps count values for all four timing sets, and each set is given different values so that a mis-wired set select shows up as a wrong phase width. A phase counted as count clocks instead of count plus one, or a zero count treated as 256, would give widths that are off by one or badly out. The ready tests release ready at chosen strobe clocks. A synchroniser with the wrong depth, or a stretch that ignores the per-device enable, would shift the strobe end by a clock or hang the cycle. The read-data check changes `ata_din` one clock before and one clock after the strobe ends, so a capture on the wrong edge returns the wrong word. Swap tests mix devices and classes to catch swapping on register accesses or on the wrong device. A start injected mid-cycle would, if accepted, change `dev_sel`, alter the selects or leave busy high after done.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

    localparam int CNT_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_STROBE = 3'd2,
        ST_WAIT   = 3'd3,
        ST_HOLD   = 3'd4,
        ST_EOC    = 3'd5
    } pio_state_t;

    // Packed with the setup count in the low byte.
    typedef struct packed {
        logic [CNT_W-1:0] eoc;
        logic [CNT_W-1:0] hold;
        logic [CNT_W-1:0] strobe;
        logic [CNT_W-1:0] setup;
    } pio_timing_t;

    localparam int TIMING_W = $bits(pio_timing_t);

endpackage

// File: rtl/ata_pio_rdy_sync.sv
module ata_pio_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/ata_pio_swap.sv
module ata_pio_swap #(
    parameter int DATA_W = 16
) (
    input  logic              enable,
    input  logic [DATA_W-1:0] word_in,
    output logic [DATA_W-1:0] word_out
);

    localparam int NBYTES = DATA_W / 8;

    logic [DATA_W-1:0] reversed;

    genvar g;
    generate
        for (g = 0; g < NBYTES; g++) begin : g_lane
            assign reversed[g*8 +: 8] = word_in[(NBYTES-1-g)*8 +: 8];
        end
    endgenerate

    assign word_out = enable ? reversed : word_in;

endmodule

// File: rtl/ata_pio_tsel.sv
module ata_pio_tsel
    import ata_pio_pkg::*;
(
    input  pio_timing_t set_reg_d0,
    input  pio_timing_t set_data_d0,
    input  pio_timing_t set_reg_d1,
    input  pio_timing_t set_data_d1,
    input  logic        sel_dev,
    input  logic        sel_data,
    output pio_timing_t sel_set
);

    pio_timing_t bank [4];

    always_comb begin
        bank[0] = set_reg_d0;
        bank[1] = set_data_d0;
        bank[2] = set_reg_d1;
        bank[3] = set_data_d1;
        sel_set = bank[{sel_dev, sel_data}];
    end

endmodule

// File: rtl/ata_pio_fsm.sv
module ata_pio_fsm
    import ata_pio_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3,
    parameter int CS_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              req_dev,
    input  logic              req_data,
    input  logic              req_wr,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [ADDR_W-1:0] req_da,
    input  logic [DATA_W-1:0] req_wdata,
    input  pio_timing_t       tim,
    input  logic [1:0]        rdy_en,
    input  logic              rdy_seen,
    output logic              busy,
    output logic              done,
    output logic              capture,
    output logic              cur_dev,
    output logic              cur_data,
    output logic              cur_wr,
    output logic [DATA_W-1:0] cur_wdata,
    output logic [CS_W-1:0]   bus_cs_n,
    output logic [ADDR_W-1:0] bus_da,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic              bus_doe
);

    pio_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              done_d, done_q;
    logic              accept;
    logic              stretch;
    logic [CS_W-1:0]   cs_q;
    logic [ADDR_W-1:0] da_q;

    assign accept  = (state_q == ST_IDLE) && start;
    assign stretch = rdy_en[cur_dev] && !rdy_seen;

    // Next-state and counter load
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        done_d  = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_SETUP;
                    cnt_d   = tim.setup;
                end
            end
            ST_SETUP: begin
                if (cnt_q == '0) begin
                    state_d = ST_STROBE;
                    cnt_d   = tim.strobe;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_STROBE: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end else if (stretch) begin
                    state_d = ST_WAIT;
                end else begin
                    state_d = ST_HOLD;
                    cnt_d   = tim.hold;
                    capture = 1'b1;
                end
            end
            ST_WAIT: begin
                if (rdy_seen) begin
                    state_d = ST_HOLD;
                    cnt_d   = tim.hold;
                    capture = 1'b1;
                end
            end
            ST_HOLD: begin
                if (cnt_q == '0) begin
                    state_d = ST_EOC;
                    cnt_d   = tim.eoc;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_EOC: begin
                if (cnt_q == '0) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            done_q    <= 1'b0;
            cur_dev   <= 1'b0;
            cur_data  <= 1'b0;
            cur_wr    <= 1'b0;
            cs_q      <= '0;
            da_q      <= '0;
            cur_wdata <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            done_q  <= done_d;
            if (accept) begin
                cur_dev   <= req_dev;
                cur_data  <= req_data;
                cur_wr    <= req_wr;
                cs_q      <= req_cs;
                da_q      <= req_da;
                cur_wdata <= req_wdata;
            end
        end
    end

    // Bus outputs
    always_comb begin
        bus_cs_n = '1;
        bus_da   = '0;
        bus_rd_n = 1'b1;
        bus_wr_n = 1'b1;
        bus_doe  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_EOC: begin
            end
            ST_SETUP, ST_HOLD: begin
                bus_cs_n = ~cs_q;
                bus_da   = da_q;
                bus_doe  = cur_wr;
            end
            ST_STROBE, ST_WAIT: begin
                bus_cs_n = ~cs_q;
                bus_da   = da_q;
                bus_doe  = cur_wr;
                bus_rd_n = cur_wr;
                bus_wr_n = !cur_wr;
            end
            default: begin
            end
        endcase
    end

    assign busy = (state_q != ST_IDLE);
    assign done = done_q;

endmodule

// File: rtl/ata_pio_timer.sv
module ata_pio_timer
    import ata_pio_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 3,
    parameter int CS_W        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                start_dev,
    input  logic                start_data,
    input  logic                start_wr,
    input  logic [CS_W-1:0]     start_cs,
    input  logic [ADDR_W-1:0]   start_da,
    input  logic [DATA_W-1:0]   start_wdata,
    input  logic [TIMING_W-1:0] tim_reg_d0,
    input  logic [TIMING_W-1:0] tim_data_d0,
    input  logic [TIMING_W-1:0] tim_reg_d1,
    input  logic [TIMING_W-1:0] tim_data_d1,
    input  logic [1:0]          rdy_en,
    input  logic [1:0]          swap_en,
    input  logic                ata_ready,
    input  logic [DATA_W-1:0]   ata_din,
    output logic [CS_W-1:0]     ata_cs_n,
    output logic [ADDR_W-1:0]   ata_da,
    output logic                ata_rd_n,
    output logic                ata_wr_n,
    output logic [DATA_W-1:0]   ata_dout,
    output logic                ata_doe,
    output logic [DATA_W-1:0]   rd_data,
    output logic                done,
    output logic                busy,
    output logic                dev_sel
);

    pio_timing_t       tim_sel;
    logic              rdy_seen;
    logic              capture;
    logic              cur_dev, cur_data, cur_wr;
    logic [DATA_W-1:0] cur_wdata;
    logic              sel_dev, sel_data;
    logic              swap_now;
    logic [DATA_W-1:0] wr_word, rd_word;
    logic [DATA_W-1:0] rd_q;

    // While idle the incoming request picks the set; afterwards the latched one.
    assign sel_dev  = busy ? cur_dev  : start_dev;
    assign sel_data = busy ? cur_data : start_data;
    assign swap_now = swap_en[cur_dev] && cur_data;

    ata_pio_tsel u_tsel (
        .set_reg_d0  (pio_timing_t'(tim_reg_d0)),
        .set_data_d0 (pio_timing_t'(tim_data_d0)),
        .set_reg_d1  (pio_timing_t'(tim_reg_d1)),
        .set_data_d1 (pio_timing_t'(tim_data_d1)),
        .sel_dev     (sel_dev),
        .sel_data    (sel_data),
        .sel_set     (tim_sel)
    );

    ata_pio_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ata_ready),
        .sync_out (rdy_seen)
    );

    ata_pio_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CS_W(CS_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .req_dev   (start_dev),
        .req_data  (start_data),
        .req_wr    (start_wr),
        .req_cs    (start_cs),
        .req_da    (start_da),
        .req_wdata (start_wdata),
        .tim       (tim_sel),
        .rdy_en    (rdy_en),
        .rdy_seen  (rdy_seen),
        .busy      (busy),
        .done      (done),
        .capture   (capture),
        .cur_dev   (cur_dev),
        .cur_data  (cur_data),
        .cur_wr    (cur_wr),
        .cur_wdata (cur_wdata),
        .bus_cs_n  (ata_cs_n),
        .bus_da    (ata_da),
        .bus_rd_n  (ata_rd_n),
        .bus_wr_n  (ata_wr_n),
        .bus_doe   (ata_doe)
    );

    ata_pio_swap #(.DATA_W(DATA_W)) u_swap_wr (
        .enable   (swap_now),
        .word_in  (cur_wdata),
        .word_out (wr_word)
    );

    ata_pio_swap #(.DATA_W(DATA_W)) u_swap_rd (
        .enable   (swap_now),
        .word_in  (ata_din),
        .word_out (rd_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 rd_q <= '0;
        else if (capture && !cur_wr) rd_q <= rd_word;
    end

    assign ata_dout = ata_doe ? wr_word : '0;
    assign rd_data  = rd_q;
    assign dev_sel  = cur_dev;

endmodule

// File: rtl/ata_pio_timer_chk.sv
module ata_pio_timer_chk #(
    parameter int CS_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic            dev_sel,
    input logic            ata_rd_n,
    input logic            ata_wr_n,
    input logic            ata_doe,
    input logic [CS_W-1:0] ata_cs_n
);

    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ata_rd_n && !ata_wr_n));

    a_r2_strobe_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (!ata_rd_n || !ata_wr_n) |-> busy);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ata_rd_n && ata_wr_n && !ata_doe && ata_cs_n == '1));

    a_r8_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        ata_doe |-> ata_rd_n);

    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(dev_sel));

    a_r11_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

bind ata_pio_timer ata_pio_timer_chk #(.CS_W(CS_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .dev_sel  (dev_sel),
    .ata_rd_n (ata_rd_n),
    .ata_wr_n (ata_wr_n),
    .ata_doe  (ata_doe),
    .ata_cs_n (ata_cs_n)
);

// File: tb/ata_pio_timer_tb_top.sv
module ata_pio_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st = 1'b0, st_dev = 1'b0, st_data = 1'b0, st_wr = 1'b0;
    logic [1:0]  st_cs = 2'b01;
    logic [2:0]  st_da = 3'd0;
    logic [15:0] st_wd = 16'h0;
    logic [31:0] cfg_r0, cfg_d0, cfg_r1, cfg_d1;
    logic [1:0]  rdy_en = 2'b00, swap_en = 2'b00;
    logic        ready = 1'b1;
    logic [15:0] din = 16'hDEAD;
    logic [1:0]  cs_n;
    logic [2:0]  da;
    logic        rd_n, wr_n, doe, done, busy, dev_sel;
    logic [15:0] dout, rd_data;

    logic [7:0]  tv [4][4];   // [set][field] set = dev*2+data, field 0..3 = setup,strobe,hold,eoc
    int          n_checks = 0;
    int          n_fail = 0;
    bit          finished = 0;
    logic [15:0] last_rd = 16'h0;

    always #5 clk = ~clk;

    always_comb begin
        cfg_r0 = {tv[0][3], tv[0][2], tv[0][1], tv[0][0]};
        cfg_d0 = {tv[1][3], tv[1][2], tv[1][1], tv[1][0]};
        cfg_r1 = {tv[2][3], tv[2][2], tv[2][1], tv[2][0]};
        cfg_d1 = {tv[3][3], tv[3][2], tv[3][1], tv[3][0]};
    end

    ata_pio_timer dut_i (
        .clk(clk), .rst_n(rst_n), .start(st), .start_dev(st_dev), .start_data(st_data),
        .start_wr(st_wr), .start_cs(st_cs), .start_da(st_da), .start_wdata(st_wd),
        .tim_reg_d0(cfg_r0), .tim_data_d0(cfg_d0), .tim_reg_d1(cfg_r1), .tim_data_d1(cfg_d1),
        .rdy_en(rdy_en), .swap_en(swap_en), .ata_ready(ready), .ata_din(din),
        .ata_cs_n(cs_n), .ata_da(da), .ata_rd_n(rd_n), .ata_wr_n(wr_n), .ata_dout(dout),
        .ata_doe(doe), .rd_data(rd_data), .done(done), .busy(busy), .dev_sel(dev_sel)
    );

    function automatic logic [15:0] bswap(input logic [15:0] w);
        return {w[7:0], w[15:8]};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // rr: strobe clock after which ready rises (-1 = leave ready as is)
    task automatic run_cycle(input logic dv, input logic cl, input logic w,
                             input logic [1:0] cs, input logic [2:0] da_v,
                             input logic [15:0] wd, input logic [15:0] dinv,
                             input int rr, input bit inject);
        int  s, e1, e2, e4, ee, idx, ws, wt, wh, we, bad, last_str;
        bit  fin, sw;
        logic [15:0] exp_out;
        s  = int'(dv) * 2 + int'(cl);
        e1 = int'(tv[s][0]) + 1;
        e2 = int'(tv[s][1]) + 1;
        e4 = int'(tv[s][2]) + 1;
        ee = int'(tv[s][3]) + 1;
        if (rdy_en[dv] && rr >= 0 && rr + 2 > e2) e2 = rr + 2;
        sw = swap_en[dv] && cl;
        exp_out = sw ? bswap(wd) : wd;
        last_str = e1 + e2;
        ws = 0; wt = 0; wh = 0; we = 0; bad = 0; fin = 0;
        din = 16'hDEAD;
        st = 1'b1; st_dev = dv; st_data = cl; st_wr = w; st_cs = cs; st_da = da_v; st_wd = wd;
        @(negedge clk);
        st = 1'b0;
        idx = 1;
        while (!fin && idx < 4000) begin
            st = 1'b0;
            if (done) begin
                fin = 1;
                if (busy) bad++;
            end else if (!busy) begin
                bad++;
            end else if (!rd_n || !wr_n) begin
                wt++;
                if (cs_n != ~cs || da != da_v || doe != w) bad++;
                if (rd_n != w || wr_n != !w) bad++;
                if (w && dout != exp_out) bad++;
            end else if (cs_n != 2'b11) begin
                if (wt == 0) ws++; else wh++;
                if (cs_n != ~cs || da != da_v || doe != w) bad++;
                if (w && dout != exp_out) bad++;
            end else begin
                we++;
                if (doe || da != 3'd0) bad++;
            end
            if (!w && idx == last_str)     din = dinv;
            if (!w && idx == last_str + 1) din = 16'hBEEF;
            if (rr >= 0 && idx == e1 + rr) ready = 1'b1;
            if (inject && idx == 3) begin
                st = 1'b1; st_dev = !dv; st_cs = ~cs; st_da = ~da_v; st_wr = !w; st_data = !cl;
            end
            if (!fin) begin
                @(negedge clk);
                idx++;
            end
        end
        st = 1'b0;
        check("R2 R3 setup width", ws, e1);
        check("R2 R5 R6 strobe width", wt, e2);
        check("R2 R3 hold width", wh, e4);
        check("R2 R3 end-of-cycle width", we, ee);
        check("R4 R8 R9 bus signals per clock", bad, 0);
        check("R11 done reached", int'(fin), 1);
        check("R12 dev_sel", int'(dev_sel), int'(dv));
        if (!w) begin
            last_rd = sw ? bswap(dinv) : dinv;
            check("R7 R9 read capture", int'(rd_data), int'(last_rd));
        end else begin
            check("R7 read data held over write", int'(rd_data), int'(last_rd));
        end
        bad = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (busy || done) bad++;
        end
        check("R10 R11 idle after cycle", bad, 0);
    endtask

    task automatic set_all(input int b1, input int b2, input int b4, input int be);
        for (int s = 0; s < 4; s++) begin
            tv[s][0] = 8'(b1 + s);
            tv[s][1] = 8'(b2 + s);
            tv[s][2] = 8'(b4 + s);
            tv[s][3] = 8'(be + s);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int k;
        int v1 [2] = '{0, 3};
        int v2 [2] = '{0, 2};
        int v4 [2] = '{0, 1};
        int ve [2] = '{0, 4};
        set_all(1, 1, 1, 1);
        idle(3);
        // R1 reset state
        check("R1 cs_n reset", int'(cs_n), 3);
        check("R1 strobes reset", int'({rd_n, wr_n}), 3);
        check("R1 busy/done/doe reset", int'({busy, done, doe}), 0);
        check("R1 da reset", int'(da), 0);
        rst_n = 1'b1;
        idle(3);

        // Sweep: all devices, classes, directions against varied counts (R2 R3 R4 R8)
        k = 0;
        for (int d = 0; d < 2; d++)
            for (int c = 0; c < 2; c++)
                for (int a = 0; a < 2; a++)
                    for (int b = 0; b < 2; b++)
                        for (int h = 0; h < 2; h++)
                            for (int e = 0; e < 2; e++) begin
                                set_all(v1[a], v2[b], v4[h], ve[e]);
                                run_cycle(d[0], c[0], k[0], 2'((k % 3) + 1), 3'(k),
                                          16'(16'h1357 + k * 16'h0101), 16'(16'h2468 + k * 3), -1, 0);
                                k++;
                            end

        // R5 ready stretch on device 0, R6 ready ignored on device 1
        set_all(1, 1, 1, 2);
        rdy_en = 2'b01;
        ready = 1'b0; idle(3);
        run_cycle(1'b0, 1'b1, 1'b0, 2'b01, 3'd0, 16'h0, 16'hA1B2, 6, 0); // strobe count 2 -> width 8
        ready = 1'b0; idle(3);
        run_cycle(1'b0, 1'b0, 1'b1, 2'b10, 3'd5, 16'h00C3, 16'h0, 0, 0); // early ready -> width count+1
        ready = 1'b0; idle(3);
        run_cycle(1'b0, 1'b0, 1'b0, 2'b01, 3'd2, 16'h0, 16'h0F0E, 2, 0); // width 4
        ready = 1'b0; idle(3);
        run_cycle(1'b1, 1'b1, 1'b0, 2'b10, 3'd1, 16'h0, 16'h7788, -1, 0); // R6: ready low, not enabled
        ready = 1'b1;
        rdy_en = 2'b11; idle(3);
        run_cycle(1'b1, 1'b0, 1'b1, 2'b01, 3'd7, 16'h0055, 16'h0, -1, 0); // ready high, count only
        rdy_en = 2'b00;

        // R9 byte swap per device and class
        swap_en = 2'b10;
        run_cycle(1'b1, 1'b1, 1'b1, 2'b01, 3'd0, 16'hC0DE, 16'h0, -1, 0);
        run_cycle(1'b1, 1'b1, 1'b0, 2'b01, 3'd0, 16'h0, 16'h3C5A, -1, 0);
        run_cycle(1'b1, 1'b0, 1'b0, 2'b10, 3'd6, 16'h0, 16'h9A0B, -1, 0);
        run_cycle(1'b0, 1'b1, 1'b0, 2'b01, 3'd3, 16'h0, 16'h4D2E, -1, 0);
        run_cycle(1'b0, 1'b1, 1'b1, 2'b01, 3'd3, 16'hF00D, 16'h0, -1, 0);
        swap_en = 2'b11;
        run_cycle(1'b0, 1'b1, 1'b0, 2'b11, 3'd4, 16'h0, 16'h1122, -1, 0);
        swap_en = 2'b00;

        // R10 start while busy is ignored
        set_all(2, 3, 2, 3);
        run_cycle(1'b0, 1'b1, 1'b1, 2'b01, 3'd2, 16'hABCD, 16'h0, -1, 1);
        run_cycle(1'b1, 1'b0, 1'b0, 2'b10, 3'd5, 16'h0, 16'h5A5A, -1, 1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule